// File: doc/BRIEF.md
# Local Interrupt Controller Base and Mode Register

This block holds the 64-bit register that places a local interrupt controller in the physical address map and selects its operating mode. The register has four fields: a page-aligned base address, a flag that marks the bootstrap processor, a global enable and an extended-mode enable. Each software write is checked against the register's current mode and against the bits that must stay zero. A write that passes every check is stored. A write that fails any check is dropped, and the block raises a fault pulse for one cycle.

The block outputs the stored value, the current mode and the decoded base address. A neighbouring address decoder uses the base address to move the controller's register window. Bit positions: bit 8 is the bootstrap flag, bit 10 is the extended enable, bit 11 is the global enable, and bits from 12 up to the physical-address width hold the base. Bits 7:0, bit 9 and all bits at or above the physical-address width are reserved and must be zero. The mode output is `{extended, enable}`: 2'b00 means disabled, 2'b01 means legacy and 2'b11 means extended. The pair enable=0, extended=1 is invalid and is never stored.

Top module: `apicbase_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0xFEE00000 with bit 11 set and bit 8 set to RESET_BSP (0xFEE00900 with the defaults), `mode_o` is legacy and `fault_o` is low.
- R2: A write that passes every check appears on `rd_data` in the cycle after `wr_en` is sampled, and `fault_o` stays low.
- R3: A write with bit 11 = 0 and bit 10 = 1 faults from every current mode.
- R4: In extended mode, a write that selects legacy (bit 11 = 1, bit 10 = 0) faults. A write that selects disabled (both bits 0) is accepted.
- R5: In disabled mode, a write that selects extended faults. A write that selects legacy is accepted.
- R6: In legacy mode, a write that selects extended is accepted.
- R7: A write that sets any bit at or above PA_WIDTH (default 36) faults. Bits just below that width are accepted.
- R8: A write that sets any of bits 7:0 or bit 9 faults.
- R9: `base_o` equals the stored bits [PA_WIDTH-1:12] with the low 12 bits zero, so the base can be moved to another page, for example 0x42000000.
- R10: Each rejected write gives a one-cycle `fault_o` pulse in the cycle after the write and leaves every output unchanged. When `wr_en` is low, the register is untouched and no fault is raised, whatever `wr_data` holds.
- R11: When X_SUPPORTED = 0, every write with bit 10 set faults.
- R12: `mode_o` uses the encoding {bit 10, bit 11}: 00 disabled, 01 legacy, 11 extended. It always matches the stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 64 | Value to be written |
| rd_data | output | 64 | Stored register value |
| mode_o | output | 2 | Current mode {extended, enable} |
| base_o | output | PA_WIDTH | Decoded page-aligned base address |
| bsp_o | output | 1 | Bootstrap-processor flag |
| fault_o | output | 1 | One-cycle pulse for a rejected write |

## Verification
The reserved-bit and width check and the mode-transition check run side by side on the same write. The bench provokes both with one write that leaves extended mode for legacy and also sets bit 0; it expects a single one-cycle fault and an unchanged register. Two writes can also overlap in time: a rejected write followed in the very next cycle by a legal one. There the bench expects the fault pulse of the first write in the same cycle that the second write is captured, and then the second write's value with the fault low.

// File: rtl/apicbase_pkg.sv
package apicbase_pkg;

  localparam int REG_W    = 64;
  localparam int BSP_BIT  = 8;
  localparam int RSV9_BIT = 9;
  localparam int EXT_BIT  = 10;
  localparam int EN_BIT   = 11;
  localparam int BASE_LSB = 12;

  // encoding is {extended, enable}
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_LEGACY  = 2'b01,
    MODE_INVALID = 2'b10,
    MODE_EXT     = 2'b11
  } mode_e;

  function automatic mode_e mode_of(input logic en, input logic ext);
    return mode_e'({ext, en});
  endfunction

endpackage

// File: rtl/apicbase_field_check.sv
module apicbase_field_check
  import apicbase_pkg::*;
#(
  parameter int PA_WIDTH = 36
) (
  input  logic [REG_W-1:0] wdata,
  output logic             rsvd_bad,
  output logic             width_bad
);

  // low reserved bits: 7:0 and 9
  localparam logic [REG_W-1:0] LOW_RSVD =
    (REG_W'(1) << RSV9_BIT) | ((REG_W'(1) << BSP_BIT) - REG_W'(1));

  assign rsvd_bad = |(wdata & LOW_RSVD);

  generate
    if (PA_WIDTH < REG_W) begin : g_high
      assign width_bad = |wdata[REG_W-1:PA_WIDTH];
    end else begin : g_full
      assign width_bad = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/apicbase_mode_fsm.sv
module apicbase_mode_fsm
  import apicbase_pkg::*;
#(
  parameter bit X_SUPPORTED = 1'b1
) (
  input  mode_e cur_mode,
  input  mode_e req_mode,
  output logic  trans_ok
);

  logic path_ok;
  logic ext_allowed;

  always_comb begin
    unique case (cur_mode)
      MODE_OFF:    path_ok = (req_mode == MODE_OFF) || (req_mode == MODE_LEGACY);
      MODE_LEGACY: path_ok = (req_mode != MODE_INVALID);
      MODE_EXT:    path_ok = (req_mode == MODE_OFF) || (req_mode == MODE_EXT);
      default:     path_ok = 1'b0;
    endcase
  end

  generate
    if (X_SUPPORTED) begin : g_ext
      assign ext_allowed = 1'b1;
    end else begin : g_noext
      assign ext_allowed = ~req_mode[1];
    end
  endgenerate

  assign trans_ok = path_ok & ext_allowed;

endmodule

// File: rtl/apicbase_reg.sv
module apicbase_reg
  import apicbase_pkg::*;
#(
  parameter int               PA_WIDTH    = 36,
  parameter bit               X_SUPPORTED = 1'b1,
  parameter logic [REG_W-1:0] RESET_BASE  = 64'h0000_0000_FEE0_0000,
  parameter bit               RESET_BSP   = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [63:0]         wr_data,
  output logic [63:0]         rd_data,
  output logic [1:0]          mode_o,
  output logic [PA_WIDTH-1:0] base_o,
  output logic                bsp_o,
  output logic                fault_o
);

  localparam logic [REG_W-1:0] RST_VAL =
    RESET_BASE | (REG_W'(RESET_BSP) << BSP_BIT) | (REG_W'(1) << EN_BIT);
  localparam logic [PA_WIDTH-1:0] RST_BASE =
    {RESET_BASE[PA_WIDTH-1:BASE_LSB], {BASE_LSB{1'b0}}};

  logic [REG_W-1:0]    reg_q;
  mode_e               mode_q;
  logic [PA_WIDTH-1:0] base_q;
  logic                fault_q;

  mode_e req_mode;
  logic  rsvd_bad, width_bad, trans_ok, reject;

  assign req_mode = mode_of(wr_data[EN_BIT], wr_data[EXT_BIT]);

  apicbase_field_check #(.PA_WIDTH(PA_WIDTH)) u_check (
    .wdata     (wr_data),
    .rsvd_bad  (rsvd_bad),
    .width_bad (width_bad)
  );

  apicbase_mode_fsm #(.X_SUPPORTED(X_SUPPORTED)) u_fsm (
    .cur_mode (mode_q),
    .req_mode (req_mode),
    .trans_ok (trans_ok)
  );

  assign reject = rsvd_bad | width_bad | ~trans_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q   <= RST_VAL;
      mode_q  <= MODE_LEGACY;
      base_q  <= RST_BASE;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_en & reject;
      if (wr_en && !reject) begin
        reg_q  <= wr_data;
        mode_q <= req_mode;
        base_q <= {wr_data[PA_WIDTH-1:BASE_LSB], {BASE_LSB{1'b0}}};
      end
    end
  end

  assign rd_data = reg_q;
  assign mode_o  = mode_q;
  assign base_o  = base_q;
  assign bsp_o   = reg_q[BSP_BIT];
  assign fault_o = fault_q;

  // ---------------- assertions ----------------
  p_fault_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> $past(wr_en));

  p_reject_holds_r10: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> $stable(reg_q));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(reg_q) && !fault_q));

  p_no_invalid_r3: assert property (@(posedge clk) disable iff (rst)
    mode_q != MODE_INVALID);

  p_ext_exit_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == MODE_EXT && mode_q != MODE_EXT) |-> mode_q == MODE_OFF);

  p_off_entry_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == MODE_OFF) |-> mode_q != MODE_EXT);

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_q[BSP_BIT-1:0] == '0) && !reg_q[RSV9_BIT]);

  p_mode_track_r12: assert property (@(posedge clk) disable iff (rst)
    mode_q == mode_of(reg_q[EN_BIT], reg_q[EXT_BIT]));

  p_base_track_r9: assert property (@(posedge clk) disable iff (rst)
    base_q == {reg_q[PA_WIDTH-1:BASE_LSB], {BASE_LSB{1'b0}}});

  generate
    if (PA_WIDTH < REG_W) begin : g_width_chk
      p_width_r7: assert property (@(posedge clk) disable iff (rst)
        reg_q[REG_W-1:PA_WIDTH] == '0);
    end
    if (!X_SUPPORTED) begin : g_unsup_chk
      p_unsup_r11: assert property (@(posedge clk) disable iff (rst)
        mode_q != MODE_EXT);
    end
  endgenerate

endmodule

// File: tb/apicbase_reg_bench.sv
`timescale 1ns/1ps
module apicbase_reg_bench;

  localparam int PA = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [1:0]  mode_o;
  logic [PA-1:0] base_o;
  logic bsp_o, fault_o;

  logic wr_en2 = 1'b0;
  logic [63:0] wr_data2 = '0;
  logic [63:0] rd_data2;
  logic [1:0]  mode2;
  logic [PA-1:0] base2;
  logic bsp2, fault2;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apicbase_reg #(.PA_WIDTH(PA)) u_apicbase_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mode_o(mode_o), .base_o(base_o),
    .bsp_o(bsp_o), .fault_o(fault_o));

  apicbase_reg #(.PA_WIDTH(PA), .X_SUPPORTED(1'b0)) u_apicbase_reg_nox (
    .clk(clk), .rst(rst), .wr_en(wr_en2), .wr_data(wr_data2),
    .rd_data(rd_data2), .mode_o(mode2), .base_o(base2),
    .bsp_o(bsp2), .fault_o(fault2));

  typedef struct packed {
    logic [63:0] wd;
    logic        flt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_FEE0_0900, 1'b0, 8'd2},  // R2 rewrite legacy
    '{64'h0000_0000_FEE0_0500, 1'b1, 8'd3},  // R3 invalid from legacy
    '{64'h0000_0000_FEE0_0D00, 1'b0, 8'd6},  // R6 legacy -> extended
    '{64'h0000_0000_FEE0_0900, 1'b1, 8'd4},  // R4 extended -> legacy
    '{64'h0000_0000_FEE0_0500, 1'b1, 8'd3},  // R3 invalid from extended
    '{64'h0000_0000_FEE0_0100, 1'b0, 8'd4},  // R4 extended -> disabled
    '{64'h0000_0000_FEE0_0500, 1'b1, 8'd3},  // R3 invalid from disabled
    '{64'h0000_0000_FEE0_0D00, 1'b1, 8'd5},  // R5 disabled -> extended
    '{64'h0000_0000_4200_0900, 1'b0, 8'd9},  // R9 R5 relocate, enter legacy
    '{64'h0000_0000_4200_0901, 1'b1, 8'd8},  // R8 bit 0
    '{64'h0000_0000_4200_0B00, 1'b1, 8'd8},  // R8 bit 9
    '{64'h0000_0010_4200_0900, 1'b1, 8'd7},  // R7 bit 36
    '{64'h0000_000F_4200_0900, 1'b0, 8'd7},  // R7 bits 35:32 legal
    '{64'h8000_0000_FEE0_0900, 1'b1, 8'd7},  // R7 bit 63
    '{64'h0000_0000_FEE0_0900, 1'b0, 8'd2}   // R2 restore
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write1(input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_state(input string req, input logic [63:0] exp_rd, input logic exp_f);
    chk(req, rd_data, exp_rd);
    chk(req, 64'(fault_o), 64'(exp_f));
    chk(req, 64'(mode_o), 64'({exp_rd[10], exp_rd[11]}));
    chk(req, 64'(base_o), 64'({exp_rd[PA-1:12], 12'h000}));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] exp_rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R12 reset state
    exp_rd = 64'h0000_0000_FEE0_0900;
    check_state("R1", exp_rd, 1'b0);
    chk("R12", 64'(mode_o), 64'h1);
    chk("R1", 64'(bsp_o), 64'h1);

    for (int i = 0; i < NV; i++) begin
      write1(VECS[i].wd);
      if (!VECS[i].flt) exp_rd = VECS[i].wd;
      check_state($sformatf("R%0d vec%0d", VECS[i].req, i), exp_rd, VECS[i].flt);
    end
    chk("R9", 64'(base_o), 64'h0_FEE0_0000);

    // R12 extended encoding
    write1(64'h0000_0000_FEE0_0D00);
    exp_rd = 64'h0000_0000_FEE0_0D00;
    chk("R12", 64'(mode_o), 64'h3);

    // same-cycle: mode-illegal and reserved bit together -> one pulse (R10 R4 R8)
    write1(64'h0000_0000_FEE0_0901);
    check_state("R10", exp_rd, 1'b1);
    @(negedge clk);
    chk("R10", 64'(fault_o), 64'h0);

    // rejected write followed directly by a legal one (R10 R4)
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'h0000_0000_FEE0_0900;
    @(negedge clk);
    wr_data = 64'h0000_0000_FEE0_0100;
    check_state("R10", exp_rd, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    exp_rd = 64'h0000_0000_FEE0_0100;
    check_state("R4", exp_rd, 1'b0);
    chk("R12", 64'(mode_o), 64'h0);

    // write strobe low: data ignored (R10)
    @(negedge clk);
    wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (2) @(negedge clk);
    check_state("R10", exp_rd, 1'b0);

    // extended unsupported instance (R11)
    @(negedge clk);
    wr_en2 = 1'b1; wr_data2 = 64'h0000_0000_FEE0_0D00;
    @(negedge clk);
    wr_en2 = 1'b0;
    chk("R11", 64'(fault2), 64'h1);
    chk("R11", rd_data2, 64'h0000_0000_FEE0_0900);
    chk("R11", 64'(mode2), 64'h1);
    @(negedge clk);
    wr_en2 = 1'b1; wr_data2 = 64'h0000_0000_FEE0_0100;
    @(negedge clk);
    wr_en2 = 1'b0;
    chk("R11", 64'(fault2), 64'h0);
    chk("R11", rd_data2, 64'h0000_0000_FEE0_0100);

    // reset from disabled returns reset state (R1)
    do_reset();
    check_state("R1", 64'h0000_0000_FEE0_0900, 1'b0);
    chk("R1", rd_data2, 64'h0000_0000_FEE0_0900);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule